// File: doc/BRIEF.md
# SDR SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM rank. After reset it holds the command bus at NOP for the power-up settling time. It then issues a precharge to all banks, a fixed number of auto-refresh commands and a mode-register load. The mode word carries the CAS latency, burst length and wrap order, which are set at build time. Every timing value is given in nanoseconds and turned into clock counts by ceiling division against a clock-period parameter.

Once initialisation is done, an interval timer builds up a refresh debt. A single owed refresh waits until the host drops its busy line. If the debt reaches two or more, the block repays it as a back-to-back burst that the host cannot interrupt. A self-refresh request moves the rank into its low-power self-refreshing state. When the request is withdrawn, the block raises the clock enable, waits two edges plus one row cycle, and then hands the bus back.

Top module: `sdr_bringup_seq`

## Requirements
- R1: After reset, CKE is high and only NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111) is issued until the power-up count expires. The first command is a precharge (0010) with address bit 10 high, issued exactly ceil(POWERUP_NS/period) cycles after reset is released.
- R2: The initialisation order is as follows. The precharge comes first. The first auto-refresh (0001) follows ceil(TRP_NS/period) cycles later. INIT_REFS auto-refreshes are issued, each ceil(TRC_NS/period) cycles after the previous one. The mode-register load (0000) comes ceil(TRC_NS/period) cycles after the last auto-refresh.
- R3: During the mode-register load, `addr[2:0]` is log2 of the burst length (1/2/4/8 → 0/1/2/3). `addr[3]` is 1 for interleaved wrap and 0 for sequential. `addr[6:4]` is the CAS latency. All other address bits and `bank` are 0.
- R4: `init_done` rises exactly 2 cycles after the mode-register load and stays high until reset.
- R5: With the host idle, auto-refreshes are issued every ceil(REFI_NS/period) cycles. The first one comes one cycle after that interval has elapsed from `init_done`. `ref_req` is high only while refresh debt is owed.
- R6: No regular auto-refresh is started in a cycle where `host_busy` is high. An owed refresh is issued on the edge at which `host_busy` is first seen low.
- R7: If the debt is two or more when a refresh starts, the whole debt is repaid back to back, each refresh ceil(TRC_NS/period) cycles apart, and `host_busy` is ignored during the burst. The debt saturates at MAX_DEBT.
- R8: No command follows an auto-refresh within ceil(TRC_NS/period) cycles.
- R9: When the block is idle with no debt and `self_ref_req` is high, it issues auto-refresh with CKE low in the same cycle. It then holds CKE low with only NOPs, and the refresh timer stays stopped, so `ref_req` stays low.
- R10: When `self_ref_req` falls, CKE goes high with NOP. `seq_busy` stays high, and only NOPs are issued, for 2 + ceil(TRC_NS/period) cycles before the block returns to idle.
- R11: `seq_busy` is high from reset until `init_done`, and in every non-idle state. It is low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_busy | input | 1 | Host is using the command bus |
| self_ref_req | input | 1 | Request to hold the rank in self-refresh |
| cke | output | 1 | Clock enable to the rank |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (A10 for precharge-all, mode word for the load) |
| bank | output | BANK_W | Bank select, always zero |
| init_done | output | 1 | Initialisation complete |
| ref_req | output | 1 | Refresh debt outstanding |
| seq_busy | output | 1 | Sequencer owns the command bus |

## Verification
The hardest situation to reach is a catch-up burst with a known debt. The debt is internal and only grows on the timer's own phase. The bench first lets one refresh go through uncontested, which gives it the phase of the timer. It then holds `host_busy` across a computed number of intervals: two intervals to reach a debt of exactly two, and ten to reach saturation. It releases `host_busy` a few cycles after a tick, so the burst ends before the next tick. It raises `host_busy` again right after the first refresh of the burst to show that the remaining refreshes still follow.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

    // Command codes as {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PRE  = 4'b0010;
    localparam logic [3:0] CMD_AREF = 4'b0001;
    localparam logic [3:0] CMD_MRS  = 4'b0000;

    // Mode-register settle time in clocks
    localparam int unsigned TMRD_CYC = 2;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_PRE_WAIT,
        ST_INIT_REF_WAIT,
        ST_MRS_WAIT,
        ST_IDLE,
        ST_REF_WAIT,
        ST_SELF_REF,
        ST_SR_EXIT
    } seq_state_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/sdr_mode_word.sv
`timescale 1ns/1ps
module sdr_mode_word #(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned CAS_LAT   = 3,
    parameter int unsigned BURST_LEN = 4,
    parameter bit          WRAP_ILV  = 1'b0
) (
    output logic [ADDR_W-1:0] word
);
    localparam logic [2:0] BL_CODE = 3'($clog2(BURST_LEN));
    localparam logic [2:0] CL_CODE = 3'(CAS_LAT);

    always_comb begin
        word      = '0;
        word[2:0] = BL_CODE;
        word[3]   = WRAP_ILV;
        word[6:4] = CL_CODE;
    end
endmodule

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
module sdr_refresh_timer #(
    parameter int unsigned INTERVAL = 1040,
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned DEBT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              consume,
    output logic [DEBT_W-1:0] debt
);
    localparam int unsigned CNT_W = $clog2(INTERVAL);

    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [DEBT_W-1:0] debt_d, debt_q;
    logic              tick;

    always_comb begin
        tick   = en && (cnt_q == CNT_W'(INTERVAL - 1));
        cnt_d  = (!en || tick) ? '0 : cnt_q + 1'b1;
        debt_d = debt_q;
        if (!en) begin
            debt_d = '0;
        end else if (tick && !consume) begin
            if (debt_q != DEBT_W'(MAX_DEBT)) debt_d = debt_q + 1'b1;
        end else if (consume && !tick) begin
            if (debt_q != '0) debt_d = debt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            debt_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            debt_q <= debt_d;
        end
    end

    assign debt = debt_q;
endmodule

// File: rtl/sdr_bringup_seq.sv
`timescale 1ns/1ps
module sdr_bringup_seq
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BANK_W     = 2,
    parameter int unsigned CLK_PS     = 7500,
    parameter int unsigned POWERUP_NS = 100000,
    parameter int unsigned TRP_NS     = 20,
    parameter int unsigned TRC_NS     = 70,
    parameter int unsigned REFI_NS    = 7800,
    parameter int unsigned INIT_REFS  = 8,
    parameter int unsigned MAX_DEBT   = 8,
    parameter int unsigned CAS_LAT    = 3,
    parameter int unsigned BURST_LEN  = 4,
    parameter bit          WRAP_ILV   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_busy,
    input  logic              self_ref_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic              init_done,
    output logic              ref_req,
    output logic              seq_busy
);
    localparam int unsigned PWR_CYC  = ns_to_cyc(POWERUP_NS, CLK_PS);
    localparam int unsigned TRP_CYC  = ns_to_cyc(TRP_NS, CLK_PS);
    localparam int unsigned TRC_CYC  = ns_to_cyc(TRC_NS, CLK_PS);
    localparam int unsigned REFI_CYC = ns_to_cyc(REFI_NS, CLK_PS);
    localparam int unsigned EXIT_CYC = TRC_CYC + 2;
    localparam int unsigned WAIT_MAX = (PWR_CYC > EXIT_CYC) ? PWR_CYC : EXIT_CYC;
    localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int unsigned INIT_W   = $clog2(INIT_REFS + 1);
    localparam int unsigned DEBT_W   = $clog2(MAX_DEBT + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [WAIT_W-1:0] wait_cnt;
        logic [INIT_W-1:0] init_refs;
        logic              burst;
        logic              cke;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic [ADDR_W-1:0] mode_word;
    logic [DEBT_W-1:0] debt;
    logic              consume;
    logic              timer_en;
    logic              wait_over;

    sdr_mode_word #(
        .ADDR_W   (ADDR_W),
        .CAS_LAT  (CAS_LAT),
        .BURST_LEN(BURST_LEN),
        .WRAP_ILV (WRAP_ILV)
    ) u_mode (
        .word(mode_word)
    );

    assign timer_en = r_q.done && (r_q.state != ST_SELF_REF) && (r_q.state != ST_SR_EXIT);

    sdr_refresh_timer #(
        .INTERVAL(REFI_CYC),
        .MAX_DEBT(MAX_DEBT),
        .DEBT_W  (DEBT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (timer_en),
        .consume(consume),
        .debt   (debt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        consume   = 1'b0;
        wait_over = (r_q.wait_cnt == '0);
        if (!wait_over) r_d.wait_cnt = r_q.wait_cnt - 1'b1;

        case (r_q.state)
            ST_PWRUP: if (wait_over) begin
                r_d.cmd      = CMD_PRE;
                r_d.addr     = '0;
                r_d.addr[10] = 1'b1;
                r_d.state    = ST_PRE_WAIT;
                r_d.wait_cnt = WAIT_W'(TRP_CYC - 1);
            end
            ST_PRE_WAIT: if (wait_over) begin
                r_d.cmd       = CMD_AREF;
                r_d.addr      = '0;
                r_d.init_refs = INIT_W'(1);
                r_d.state     = ST_INIT_REF_WAIT;
                r_d.wait_cnt  = WAIT_W'(TRC_CYC - 1);
            end
            ST_INIT_REF_WAIT: if (wait_over) begin
                if (r_q.init_refs == INIT_W'(INIT_REFS)) begin
                    r_d.cmd      = CMD_MRS;
                    r_d.addr     = mode_word;
                    r_d.state    = ST_MRS_WAIT;
                    r_d.wait_cnt = WAIT_W'(TMRD_CYC - 1);
                end else begin
                    r_d.cmd       = CMD_AREF;
                    r_d.init_refs = r_q.init_refs + 1'b1;
                    r_d.wait_cnt  = WAIT_W'(TRC_CYC - 1);
                end
            end
            ST_MRS_WAIT: if (wait_over) begin
                r_d.addr  = '0;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (debt != '0 && !host_busy) begin
                    r_d.cmd      = CMD_AREF;
                    consume      = 1'b1;
                    r_d.burst    = (debt > DEBT_W'(1));
                    r_d.state    = ST_REF_WAIT;
                    r_d.wait_cnt = WAIT_W'(TRC_CYC - 1);
                end else if (self_ref_req && !host_busy && debt == '0) begin
                    r_d.cmd   = CMD_AREF;
                    r_d.cke   = 1'b0;
                    r_d.state = ST_SELF_REF;
                end
            end
            ST_REF_WAIT: if (wait_over) begin
                if (r_q.burst && debt != '0) begin
                    r_d.cmd      = CMD_AREF;
                    consume      = 1'b1;
                    r_d.wait_cnt = WAIT_W'(TRC_CYC - 1);
                end else begin
                    r_d.burst = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            ST_SELF_REF: if (!self_ref_req) begin
                r_d.cke      = 1'b1;
                r_d.state    = ST_SR_EXIT;
                r_d.wait_cnt = WAIT_W'(EXIT_CYC - 1);
            end
            ST_SR_EXIT: if (wait_over) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_PWRUP;
            r_q.wait_cnt  <= WAIT_W'(PWR_CYC - 1);
            r_q.init_refs <= '0;
            r_q.burst     <= 1'b0;
            r_q.cke       <= 1'b1;
            r_q.cmd       <= CMD_NOP;
            r_q.addr      <= '0;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke       = r_q.cke;
    assign cs_n      = r_q.cmd[3];
    assign ras_n     = r_q.cmd[2];
    assign cas_n     = r_q.cmd[1];
    assign we_n      = r_q.cmd[0];
    assign addr      = r_q.addr;
    assign bank      = '0;
    assign init_done = r_q.done;
    assign ref_req   = (debt != '0);
    assign seq_busy  = (r_q.state != ST_IDLE);
endmodule

// File: rtl/sdr_seq_checker.sv
`timescale 1ns/1ps
module sdr_seq_checker
    import sdr_seq_pkg::*;
#(
    parameter int unsigned CLK_PS = 7500,
    parameter int unsigned TRC_NS = 70
) (
    input logic clk,
    input logic rst_n,
    input logic host_busy,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic pre_all_bit,
    input logic init_done,
    input logic seq_busy
);
    localparam int unsigned TRC_CYC = ns_to_cyc(TRC_NS, CLK_PS);

    logic [3:0]  cmd;
    logic [15:0] since_ref;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_ref <= '1;
        else if (cmd == CMD_AREF)   since_ref <= 16'd1;
        else if (since_ref != '1)   since_ref <= since_ref + 16'd1;
    end

    assert_pre_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> pre_all_bit);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(cmd == CMD_MRS, 2));

    assert_host_yield_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF && cke && $past(!seq_busy)) |-> $past(!host_busy));

    assert_ref_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (since_ref >= 16'(TRC_CYC)));

    assert_sr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (cmd == CMD_NOP));

    assert_exit_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (seq_busy && cmd == CMD_NOP));

    assert_busy_before_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> seq_busy);
endmodule

bind sdr_bringup_seq sdr_seq_checker #(
    .CLK_PS(CLK_PS),
    .TRC_NS(TRC_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_busy  (host_busy),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .pre_all_bit(addr[10]),
    .init_done  (init_done),
    .seq_busy   (seq_busy)
);

// File: tb/tb_sdr_bringup_seq.sv
`timescale 1ns/1ps
module tb_sdr_bringup_seq;
    import sdr_seq_pkg::*;

    localparam int CLK_PS  = 5000;
    localparam int PWR_C   = (10000 * 1000 + CLK_PS - 1) / CLK_PS;  // 2000
    localparam int TRP_C   = (20 * 1000 + CLK_PS - 1) / CLK_PS;     // 4
    localparam int TRC_C   = (70 * 1000 + CLK_PS - 1) / CLK_PS;     // 14
    localparam int REFI_C  = (2000 * 1000 + CLK_PS - 1) / CLK_PS;   // 400
    localparam int MAXD    = 8;
    localparam logic [12:0] MODE_EXP = 13'h02B;  // CL2, interleaved, BL8
    localparam logic [3:0]  DONE_MK  = 4'hF;

    // {expected command, cycles since previous event}
    localparam logic [19:0] INIT_VEC [0:10] = '{
        {CMD_PRE,  16'(PWR_C)},
        {CMD_AREF, 16'(TRP_C)},
        {CMD_AREF, 16'(TRC_C)}, {CMD_AREF, 16'(TRC_C)}, {CMD_AREF, 16'(TRC_C)},
        {CMD_AREF, 16'(TRC_C)}, {CMD_AREF, 16'(TRC_C)}, {CMD_AREF, 16'(TRC_C)},
        {CMD_AREF, 16'(TRC_C)},
        {CMD_MRS,  16'(TRC_C)},
        {DONE_MK,  16'(TMRD_CYC)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_busy = 1'b0;
    logic self_ref_req = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, ref_req, seq_busy;
    logic [12:0] addr;
    logic [1:0]  bank;
    logic [3:0]  cmd_w;
    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cmd_w = {cs_n, ras_n, cas_n, we_n};

    sdr_bringup_seq #(
        .ADDR_W(13), .BANK_W(2), .CLK_PS(CLK_PS), .POWERUP_NS(10000),
        .TRP_NS(20), .TRC_NS(70), .REFI_NS(2000), .INIT_REFS(8),
        .MAX_DEBT(MAXD), .CAS_LAT(2), .BURST_LEN(8), .WRAP_ILV(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .self_ref_req(self_ref_req),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .bank(bank), .init_done(init_done), .ref_req(ref_req),
        .seq_busy(seq_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycles until the next non-NOP command
    task automatic wait_cmd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cmd_w == CMD_NOP && n < 5000);
    endtask

    task automatic wait_until(input int target, output bit quiet);
        quiet = 1'b1;
        while (cyc < target) begin
            @(negedge clk);
            if (cmd_w != CMD_NOP) quiet = 1'b0;
        end
    endtask

    task automatic burst_check(input int exp_cnt, input string req);
        int n;
        bit quiet;
        wait_cmd(n);
        chk(n == 1 && cmd_w == CMD_AREF, req, n, 1);
        host_busy = 1'b1;  // must not stop the burst
        for (int k = 1; k < exp_cnt; k++) begin
            wait_cmd(n);
            chk(n == TRC_C && cmd_w == CMD_AREF, req, n, TRC_C);
        end
        wait_until(cyc + TRC_C + 40, quiet);
        chk(quiet, req, int'(quiet), 1);
    endtask

    initial begin
        int n;
        int tick0;
        bit quiet;
        bit ok;

        // reset state (R1, R11)
        repeat (3) @(negedge clk);
        chk(cke == 1'b1, "R1 cke in reset", int'(cke), 1);
        chk(cmd_w == CMD_NOP, "R1 nop in reset", int'(cmd_w), int'(CMD_NOP));
        chk(init_done == 1'b0, "R4 done in reset", int'(init_done), 0);
        chk(seq_busy == 1'b1, "R11 busy in reset", int'(seq_busy), 1);
        rst_n = 1'b1;

        // initialisation walk (R1, R2, R3, R4)
        for (int i = 0; i < 11; i++) begin
            logic [3:0] ec;
            int eg;
            ec = INIT_VEC[i][19:16];
            eg = int'(INIT_VEC[i][15:0]);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!((ec == DONE_MK) ? init_done : (cmd_w != CMD_NOP)) && n < 5000);
            if (ec == DONE_MK) begin
                chk(n == eg, "R4 done delay", n, eg);
            end else begin
                chk(n == eg, (i == 0) ? "R1 power-up wait" : "R2 init gap", n, eg);
                chk(cmd_w == ec, "R2 init command", int'(cmd_w), int'(ec));
                if (ec == CMD_PRE) chk(addr[10] == 1'b1, "R1 precharge all", int'(addr[10]), 1);
                if (ec == CMD_MRS) begin
                    chk(addr == MODE_EXP, "R3 mode word", int'(addr), int'(MODE_EXP));
                    chk(bank == 2'b00, "R3 bank zero", int'(bank), 0);
                end
            end
        end
        chk(seq_busy == 1'b0, "R11 idle after init", int'(seq_busy), 0);

        // periodic refresh (R5)
        wait_cmd(n);
        chk(n == REFI_C + 1 && cmd_w == CMD_AREF, "R5 first refresh", n, REFI_C + 1);
        tick0 = cyc - 1;
        chk(ref_req == 1'b0, "R5 debt cleared", int'(ref_req), 0);
        chk(seq_busy == 1'b1, "R11 busy in refresh", int'(seq_busy), 1);
        chk(init_done == 1'b1, "R4 done held", int'(init_done), 1);
        wait_cmd(n);
        chk(n == REFI_C && cmd_w == CMD_AREF, "R5 interval", n, REFI_C);

        // host arbitration (R6)
        host_busy = 1'b1;
        wait_until(tick0 + 3 * REFI_C + 10, quiet);
        chk(quiet, "R6 held off", int'(quiet), 1);
        chk(ref_req == 1'b1, "R5 ref_req owed", int'(ref_req), 1);
        host_busy = 1'b0;
        @(negedge clk);
        chk(cmd_w == CMD_AREF, "R6 grant on release", int'(cmd_w), int'(CMD_AREF));

        // catch-up with debt of two (R7)
        host_busy = 1'b1;
        wait_until(tick0 + 5 * REFI_C + 5, quiet);
        host_busy = 1'b0;
        burst_check(2, "R7 debt two");

        // saturated debt (R7)
        wait_until(tick0 + 15 * REFI_C + 5, quiet);
        host_busy = 1'b0;
        burst_check(MAXD, "R7 saturated");
        host_busy = 1'b0;

        // self-refresh entry (R9)
        @(negedge clk);
        self_ref_req = 1'b1;
        @(negedge clk);
        chk(cmd_w == CMD_AREF && cke == 1'b0, "R9 entry", int'({cke, cmd_w}), int'({1'b0, CMD_AREF}));
        ok = 1'b1;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (cke != 1'b0 || cmd_w != CMD_NOP || ref_req != 1'b0) ok = 1'b0;
        end
        chk(ok, "R9 held in self-refresh", int'(ok), 1);

        // self-refresh exit (R10)
        self_ref_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1 && seq_busy == 1'b1, "R10 exit cke", int'({cke, seq_busy}), 3);
        n = 0;
        ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (cmd_w != CMD_NOP) ok = 1'b0;
        end while (seq_busy && n < 5000);
        chk(n == TRC_C + 2, "R10 exit wait", n, TRC_C + 2);
        chk(ok, "R10 nop during exit", int'(ok), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule